// File: doc/BRIEF.md
# Per-Application Memory Behaviour Profiler

This block watches the memory traffic of several applications, one per core, over a fixed window of clock cycles. For each application it counts retired instructions, last-level cache misses, memory accesses and row-buffer hits. When the window closes, it takes a copy of the counts, clears the live counters so the next window starts at once, and works through the copied counts one application at a time with a single shared sequential divider.

Two ratios are derived per application. Memory intensity is misses per thousand instructions. Row locality is the integer percentage of memory accesses that hit an open row. A two-stage test sorts each application into one of three groups. An intensity below the intensity threshold means a low-intensity group, whatever the locality. A high-intensity application is then split by the locality threshold into a poor-locality group and a good-locality group.

The group codes and intensity values of one window appear together, all at once, during the following window. A one-cycle strobe marks that moment. A channel-partitioning policy can use these results while the next profile is being gathered.

Top module: `mem_behaviour_profiler`

## Requirements
- R1: Each application's four event inputs are counted on every clock edge where they are high. A window is INTERVAL_LEN cycles long, and the first window begins at the first edge after reset is released. An event in the last cycle of a window belongs to that window, and the counters restart from zero in the next cycle.
- R2: The reported intensity of application i is floor(misses*1000/instructions), saturated at 2^MPKI_W-1. It is 0 when the window had no instructions. It appears on mpki_q bits [i*MPKI_W +: MPKI_W].
- R3: Each event counter saturates at 2^CNT_W-1 and never wraps within a window.
- R4: The locality rate is floor(hits*100/accesses), clamped to 100. It is 0 when the window had no memory accesses.
- R5: group_q bits [2i +: 2] hold application i's group. The code is 2'b00 when intensity < intensity threshold. Otherwise it is 2'b01 when rate < rate threshold and 2'b10 when it is not. The code 2'b11 never appears.
- R6: Both thresholds are sampled in the last cycle of a window. Changing them afterwards does not affect that window's results.
- R7: group_q and mpki_q reset to zero and change only in the cycle where done is high, when every application's fields update together. At all other times they hold.
- R8: done is a single-cycle pulse. It is asserted exactly once per completed window, after that window ends and before the next one ends.
- R9: INTERVAL_LEN must exceed the time needed to work through all applications. At each window end the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| instr_ret | input | N_APPS | Per-application retired-instruction pulse |
| llc_miss | input | N_APPS | Per-application last-level cache miss pulse |
| mem_acc | input | N_APPS | Per-application memory access pulse |
| row_hit | input | N_APPS | Per-application row-buffer hit pulse |
| mpki_thr | input | MPKI_W | Intensity threshold, misses per thousand instructions |
| rate_thr | input | RATE_W | Locality threshold, percent |
| group_q | output | 2*N_APPS | Packed group codes, two bits per application |
| mpki_q | output | N_APPS*MPKI_W | Packed intensity values |
| done | output | 1 | One-cycle strobe marking new results |

## Verification
Several properties are checked on every cycle:
- each counter holds at its ceiling and stays still when nothing happens;
- every quotient from the divider satisfies the division identity with a remainder below the divisor;
- done never lasts two cycles;
- the outputs move only with done;
- no illegal group code appears;
- the sequencer is idle whenever a window closes.

Only the bench scenarios can show the rest: the exact numeric results, the behaviour at the threshold boundaries, the zero-denominator cases, clamping above 100 percent, and thresholds being captured at the window edge rather than read later. To cover these, the bench runs windows with traffic patterns, threshold pairs and mid-computation threshold changes chosen for that purpose.

// File: rtl/mprof_pkg.sv
package mprof_pkg;

  typedef enum logic [1:0] {
    GRP_LOW       = 2'b00,
    GRP_HI_SPARSE = 2'b01,
    GRP_HI_DENSE  = 2'b10
  } grp_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MPKI_GO,
    S_MPKI_WAIT,
    S_RATE_GO,
    S_RATE_WAIT,
    S_PUBLISH
  } seq_t;

  // event slot order inside a per-application counter group
  localparam int unsigned EV_INSTR = 0;
  localparam int unsigned EV_MISS  = 1;
  localparam int unsigned EV_ACC   = 2;
  localparam int unsigned EV_HIT   = 3;
  localparam int unsigned EV_NUM   = 4;

  localparam int unsigned MILLE = 1000;
  localparam int unsigned PCT   = 100;

endpackage

// File: rtl/mprof_satcnt.sv
module mprof_satcnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] nxt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    nxt   = (&cnt_q) ? cnt_q : cnt_q + W'(inc);
    cnt_d = clr ? '0 : nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a full counter stays full until the window clears it
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (&cnt_q)) |=> (&cnt_q));

  // R1: no event, no clear -> the count does not move
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));

endmodule

// File: rtl/mprof_divider.sv
module mprof_divider #(
  parameter int unsigned NW = 26,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          valid,
  output logic [NW-1:0] quo
);

  localparam int unsigned CW = $clog2(NW + 1);

  logic [NW-1:0] q_q, q_d, n_q, n_d;
  logic [DW:0]   r_q, r_d;
  logic [DW-1:0] d_q, d_d;
  logic [CW-1:0] c_q, c_d;
  logic          b_q, b_d, v_q, v_d, z_q, z_d;

  logic [DW:0]   r_sh;
  logic          fits;

  always_comb begin
    r_sh = {r_q[DW-1:0], q_q[NW-1]};
    fits = (r_sh >= {1'b0, d_q});
    q_d = q_q; n_d = n_q; r_d = r_q; d_d = d_q;
    c_d = c_q; b_d = b_q; z_d = z_q; v_d = 1'b0;
    if (start) begin
      q_d = num; n_d = num; r_d = '0; d_d = den;
      z_d = (den == '0); c_d = CW'(NW); b_d = 1'b1;
    end else if (b_q) begin
      q_d = {q_q[NW-2:0], fits};
      r_d = fits ? (r_sh - {1'b0, d_q}) : r_sh;
      c_d = c_q - CW'(1);
      if (c_q == CW'(1)) begin
        b_d = 1'b0;
        v_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0; n_q <= '0; r_q <= '0; d_q <= '0;
      c_q <= '0; b_q <= 1'b0; v_q <= 1'b0; z_q <= 1'b0;
    end else begin
      q_q <= q_d; n_q <= n_d; r_q <= r_d; d_q <= d_d;
      c_q <= c_d; b_q <= b_d; v_q <= v_d; z_q <= z_d;
    end
  end

  assign busy  = b_q;
  assign valid = v_q;
  assign quo   = z_q ? '0 : q_q;

  logic [NW+DW-1:0] chk_prod, chk_num, chk_den;
  assign chk_prod = (NW+DW)'(quo) * (NW+DW)'(d_q);
  assign chk_num  = (NW+DW)'(n_q);
  assign chk_den  = (NW+DW)'(d_q);

  // R2: the quotient satisfies num = quo*den + rem with rem < den
  p_div_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !z_q) |-> ((chk_prod <= chk_num) && ((chk_num - chk_prod) < chk_den)));

endmodule

// File: rtl/mprof_classify.sv
module mprof_classify
  import mprof_pkg::*;
#(
  parameter int unsigned MPKI_W = 12,
  parameter int unsigned RATE_W = 7
) (
  input  logic [MPKI_W-1:0] mpki,
  input  logic [MPKI_W-1:0] thr_m,
  input  logic [RATE_W-1:0] rate,
  input  logic [RATE_W-1:0] thr_r,
  output grp_t              grp
);

  always_comb begin
    if (mpki < thr_m)      grp = GRP_LOW;
    else if (rate < thr_r) grp = GRP_HI_SPARSE;
    else                   grp = GRP_HI_DENSE;
  end

endmodule

// File: rtl/mem_behaviour_profiler.sv
module mem_behaviour_profiler
  import mprof_pkg::*;
#(
  parameter int unsigned N_APPS       = 24,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned MPKI_W       = 12,
  parameter int unsigned RATE_W       = 7,
  parameter int unsigned INTERVAL_LEN = 100000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_APPS-1:0]        instr_ret,
  input  logic [N_APPS-1:0]        llc_miss,
  input  logic [N_APPS-1:0]        mem_acc,
  input  logic [N_APPS-1:0]        row_hit,
  input  logic [MPKI_W-1:0]        mpki_thr,
  input  logic [RATE_W-1:0]        rate_thr,
  output logic [2*N_APPS-1:0]      group_q,
  output logic [N_APPS*MPKI_W-1:0] mpki_q,
  output logic                     done
);

  localparam int unsigned NUM_W = CNT_W + 10;
  localparam int unsigned IDX_W = (N_APPS > 1) ? $clog2(N_APPS) : 1;
  localparam int unsigned IV_W  = (INTERVAL_LEN > 1) ? $clog2(INTERVAL_LEN) : 1;
  localparam logic [NUM_W-1:0]  K_MILLE  = NUM_W'(MILLE);
  localparam logic [NUM_W-1:0]  K_PCT    = NUM_W'(PCT);
  localparam logic [MPKI_W-1:0] MPKI_MAX = {MPKI_W{1'b1}};

  // ---------------- window timer ----------------
  logic [IV_W-1:0] ic_q, ic_d;
  logic            iv_end;

  always_comb begin
    iv_end = (ic_q == IV_W'(INTERVAL_LEN - 1));
    ic_d   = iv_end ? '0 : ic_q + IV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ic_q <= '0;
    else        ic_q <= ic_d;
  end

  // ---------------- live counters and snapshot ----------------
  logic [EV_NUM-1:0]              ev      [N_APPS];
  logic [EV_NUM-1:0][CNT_W-1:0]   cnt_nxt [N_APPS];
  logic [EV_NUM-1:0][CNT_W-1:0]   snap    [N_APPS];

  for (genvar i = 0; i < N_APPS; i++) begin : g_app
    assign ev[i] = {row_hit[i], mem_acc[i], llc_miss[i], instr_ret[i]};
    for (genvar k = 0; k < EV_NUM; k++) begin : g_ev
      mprof_satcnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev[i][k]),
        .clr   (iv_end),
        .nxt   (cnt_nxt[i][k])
      );
    end
  end

  logic [MPKI_W-1:0] thr_m_q;
  logic [RATE_W-1:0] thr_r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_APPS; i++) snap[i] <= '0;
      thr_m_q <= '0;
      thr_r_q <= '0;
    end else if (iv_end) begin
      for (int i = 0; i < N_APPS; i++) snap[i] <= cnt_nxt[i];
      thr_m_q <= mpki_thr;
      thr_r_q <= rate_thr;
    end
  end

  // ---------------- shared divider ----------------
  logic             div_start, div_busy, div_valid;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [CNT_W-1:0] div_den;

  mprof_divider #(.NW(NUM_W), .DW(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .valid (div_valid),
    .quo   (div_quo)
  );

  // ---------------- sequencer ----------------
  seq_t              st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [MPKI_W-1:0] mpki_tmp_q, mpki_sat;
  logic [RATE_W-1:0] rate_clamp;
  logic              mpki_we, stage_we, pub_we;
  grp_t              grp_now;

  always_comb begin
    mpki_sat   = (div_quo > NUM_W'(MPKI_MAX)) ? MPKI_MAX : div_quo[MPKI_W-1:0];
    rate_clamp = (div_quo > K_PCT) ? RATE_W'(PCT) : div_quo[RATE_W-1:0];
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q;
    div_start = 1'b0; div_num = '0; div_den = '0;
    mpki_we = 1'b0; stage_we = 1'b0; pub_we = 1'b0;
    case (st_q)
      S_IDLE: if (iv_end) begin
        idx_d = '0;
        st_d  = S_MPKI_GO;
      end
      S_MPKI_GO: begin
        div_start = 1'b1;
        div_num   = NUM_W'(snap[idx_q][EV_MISS]) * K_MILLE;
        div_den   = snap[idx_q][EV_INSTR];
        st_d      = S_MPKI_WAIT;
      end
      S_MPKI_WAIT: if (div_valid) begin
        mpki_we = 1'b1;
        st_d    = S_RATE_GO;
      end
      S_RATE_GO: begin
        div_start = 1'b1;
        div_num   = NUM_W'(snap[idx_q][EV_HIT]) * K_PCT;
        div_den   = snap[idx_q][EV_ACC];
        st_d      = S_RATE_WAIT;
      end
      S_RATE_WAIT: if (div_valid) begin
        stage_we = 1'b1;
        if (idx_q == IDX_W'(N_APPS - 1)) st_d = S_PUBLISH;
        else begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = S_MPKI_GO;
        end
      end
      S_PUBLISH: begin
        pub_we = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  mprof_classify #(.MPKI_W(MPKI_W), .RATE_W(RATE_W)) u_cls (
    .mpki  (mpki_tmp_q),
    .thr_m (thr_m_q),
    .rate  (rate_clamp),
    .thr_r (thr_r_q),
    .grp   (grp_now)
  );

  // ---------------- staging and published results ----------------
  grp_t              stage_grp  [N_APPS];
  logic [MPKI_W-1:0] stage_mpki [N_APPS];
  grp_t              out_grp    [N_APPS];
  logic [MPKI_W-1:0] out_mpki   [N_APPS];
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpki_tmp_q <= '0;
      done_q     <= 1'b0;
      for (int i = 0; i < N_APPS; i++) begin
        stage_grp[i]  <= GRP_LOW;
        stage_mpki[i] <= '0;
        out_grp[i]    <= GRP_LOW;
        out_mpki[i]   <= '0;
      end
    end else begin
      done_q <= pub_we;
      if (mpki_we) mpki_tmp_q <= mpki_sat;
      if (stage_we) begin
        stage_grp[idx_q]  <= grp_now;
        stage_mpki[idx_q] <= mpki_tmp_q;
      end
      if (pub_we) begin
        for (int i = 0; i < N_APPS; i++) begin
          out_grp[i]  <= stage_grp[i];
          out_mpki[i] <= stage_mpki[i];
        end
      end
    end
  end

  assign done = done_q;

  for (genvar i = 0; i < N_APPS; i++) begin : g_out
    assign group_q[2*i +: 2]         = out_grp[i];
    assign mpki_q[i*MPKI_W +: MPKI_W] = out_mpki[i];

    // R5: no application ever reports the unused code
    p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      group_q[2*i +: 2] != 2'b11);
  end

  // R8: the strobe lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: results move only together with the strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(group_q) && $stable(mpki_q)));

  // R9: the previous window's work is finished before the next snapshot
  p_interval_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iv_end |-> (st_q == S_IDLE && !div_busy));

endmodule

// File: tb/sim_mem_behaviour_profiler.sv
module sim_mem_behaviour_profiler;

  localparam int N  = 4;
  localparam int CW = 8;
  localparam int MW = 10;
  localparam int RW = 7;
  localparam int L  = 300;
  localparam int NWIN = 5;
  localparam int CMAX = (1 << CW) - 1;
  localparam int MMAX = (1 << MW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    instr_ret, llc_miss, mem_acc, row_hit;
  logic [MW-1:0]   mpki_thr;
  logic [RW-1:0]   rate_thr;
  logic [2*N-1:0]  group_q;
  logic [N*MW-1:0] mpki_q;
  logic            done;

  always #2 clk = ~clk;  // 250 MHz

  mem_behaviour_profiler #(
    .N_APPS(N), .CNT_W(CW), .MPKI_W(MW), .RATE_W(RW), .INTERVAL_LEN(L)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .instr_ret(instr_ret), .llc_miss(llc_miss), .mem_acc(mem_acc), .row_hit(row_hit),
    .mpki_thr(mpki_thr), .rate_thr(rate_thr),
    .group_q(group_q), .mpki_q(mpki_q), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_cnt [N][4];
  int pend_g [N], pend_m [N], pub_g [N], pub_m [N];
  int ends = 0, dones = 0;

  int thr_m_tab [NWIN] = '{20, 1000, 50, 0, 30};
  int thr_r_tab [NWIN] = '{50, 0, 50, 101, 30};

  // pulse periods per window/app: {instr, miss, acc, hit}, 0 = never
  function automatic int period(int w, int a, int k);
    int p [4];
    case (w * 4 + a)
      0:  p = '{1, 100, 0, 0};
      1:  p = '{1, 10, 2, 3};
      2:  p = '{1, 5, 2, 10};
      4:  p = '{1, 1, 3, 3};
      5:  p = '{0, 7, 0, 0};
      6:  p = '{2, 1, 4, 2};
      7:  p = '{4, 2, 0, 5};
      8:  p = '{3, 40, 5, 0};
      9:  p = '{3, 50, 5, 10};
      10: p = '{6, 100, 5, 12};
      11: p = '{2, 75, 4, 10};
      12: p = '{1, 3, 1, 1};
      13: p = '{2, 2, 2, 4};
      14: p = '{5, 9, 3, 6};
      default: p = '{0, 0, 0, 0};
    endcase
    return p[k];
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0;
    instr_ret = '0; llc_miss = '0; mem_acc = '0; row_hit = '0;
    mpki_thr = '0; rate_thr = '0;
    for (int a = 0; a < N; a++) begin
      for (int k = 0; k < 4; k++) m_cnt[a][k] = 0;
      pub_g[a] = 0; pub_m[a] = 0; pend_g[a] = 0; pend_m[a] = 0;
    end
    repeat (4) @(negedge clk);
    // R7: reset values
    check(done == 1'b0, "R7", "done in reset", int'(done), 0);
    check(group_q == '0, "R7", "group_q in reset", int'(group_q), 0);
    check(mpki_q == '0, "R7", "mpki_q in reset", int'(mpki_q), 0);
    rst_n = 1'b1;

    for (int c = 0; c < NWIN * L + 250; c++) begin
      int w, pos;
      w = c / L;
      pos = c % L;
      // R6: thresholds for a window are set right after the previous one ends,
      // so they differ from the captured ones while the divider is still working
      if (pos == 0 && w < NWIN) begin
        mpki_thr = MW'(thr_m_tab[w]);
        rate_thr = RW'(thr_r_tab[w]);
      end
      for (int a = 0; a < N; a++) begin
        int p [4];
        for (int k = 0; k < 4; k++) p[k] = period(w, a, k);
        instr_ret[a] = (p[0] != 0) && (pos % p[0] == 0);
        llc_miss[a]  = (p[1] != 0) && (pos % p[1] == 0);
        mem_acc[a]   = (p[2] != 0) && (pos % p[2] == 0);
        row_hit[a]   = (p[3] != 0) && (pos % p[3] == 0);
      end
      @(posedge clk);
      // R1/R3: model counters, saturating
      for (int a = 0; a < N; a++) begin
        bit e [4];
        e[0] = instr_ret[a]; e[1] = llc_miss[a]; e[2] = mem_acc[a]; e[3] = row_hit[a];
        for (int k = 0; k < 4; k++)
          if (e[k] && m_cnt[a][k] < CMAX) m_cnt[a][k]++;
      end
      if (pos == L - 1) begin
        // R8: previous window's strobe must have arrived before this end
        check(dones == ends, "R8", "strobes before window end", dones, ends);
        for (int a = 0; a < N; a++) begin
          int mp, rt;
          // R2: intensity, zero instructions -> 0, saturate
          mp = (m_cnt[a][0] == 0) ? 0 : (m_cnt[a][1] * 1000) / m_cnt[a][0];
          if (mp > MMAX) mp = MMAX;
          // R4: rate, zero accesses -> 0, clamp at 100
          rt = (m_cnt[a][2] == 0) ? 0 : (m_cnt[a][3] * 100) / m_cnt[a][2];
          if (rt > 100) rt = 100;
          // R5: two-stage grouping with thresholds captured here (R6)
          pend_m[a] = mp;
          pend_g[a] = (mp < int'(mpki_thr)) ? 0 : ((rt < int'(rate_thr)) ? 1 : 2);
          for (int k = 0; k < 4; k++) m_cnt[a][k] = 0;
        end
        ends++;
      end
      @(negedge clk);
      if (done) begin
        dones++;
        check(dones == ends, "R8", "strobe count at strobe", dones, ends);
        for (int a = 0; a < N; a++) begin
          pub_g[a] = pend_g[a];
          pub_m[a] = pend_m[a];
          check(int'(group_q[2*a +: 2]) == pub_g[a], "R5", $sformatf("group app %0d", a),
                int'(group_q[2*a +: 2]), pub_g[a]);
          check(int'(mpki_q[a*MW +: MW]) == pub_m[a], "R2", $sformatf("intensity app %0d", a),
                int'(mpki_q[a*MW +: MW]), pub_m[a]);
        end
      end
      // R7: outputs always equal the last published set, every cycle
      begin
        bit same;
        same = 1'b1;
        for (int a = 0; a < N; a++)
          if (int'(group_q[2*a +: 2]) != pub_g[a] || int'(mpki_q[a*MW +: MW]) != pub_m[a])
            same = 1'b0;
        check(same, "R7", "outputs vs published", int'(group_q), pub_g[0]);
      end
      check(!(done && dones > ends), "R8", "strobe without window", dones, ends);
    end

    // R8 and R9: every window produced exactly one strobe
    check(dones == NWIN && ends == NWIN, "R8", "total strobes", dones, NWIN);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: got %0d strobes expected %0d", dones, NWIN);
      summary();
      $finish;
    end
  end

endmodule